// File: doc/BRIEF.md
# Key-Protected Watchdog Reset Timer

This block is a watchdog that software must service at regular intervals. It runs on a fast system clock and takes a one-cycle strobe, `ref_tick`, once per period of a slow 32 kHz reference. It divides that strobe into coarse timeout units. Each unit is `PRESCALE` reference periods, 512 by default, so about 62.5 units make one second.

Software programs a timeout length and picks what happens when the timeout runs out. The options are a reset pulse, an interrupt, or an interrupt followed by a reset if the interrupt goes unanswered. While the timer runs, software proves it is alive by writing a fixed restart code. It can also request a reset pulse at once.

Every register write must carry a key that belongs to its register. A write without the right key changes nothing, so a stray store into the block cannot stop the watchdog or trigger a reset by accident. Reads return the mode bits and the stored length, so software can record whether the timer was running before a suspend and restore that state afterwards.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the mode register (address 0x00) reads 0, the length register (address 0x04) reads `RST_LEN << 5`, and both `wdt_irq` and `wdt_rst` are low.
- R2: A write to address 0x00 takes effect only when `bus_wdata[31:24]` is 0x22. The mode bits are: bit 0 enable, bit 2 external reset enable, bit 3 interrupt mode, bit 6 dual mode. A read returns those four bits in the same positions, with every other bit zero.
- R3: A write to address 0x04 takes effect only when `bus_wdata[4:0]` is 0x08. The length is held in `bus_wdata[5+LEN_W-1:5]`. A read returns the length in the same bits, with bits 4:0 reading zero. Writing a new length does not reload a running count; the new value is used from the next reload.
- R4: One timeout unit is `PRESCALE` `ref_tick` strobes while the timer is enabled. The timer expires on the strobe that completes the L-th unit after a reload, where L is the stored length.
- R5: Writing exactly 0x1971 to address 0x08 reloads the count from the stored length, clears the partial unit, clears `wdt_irq` and returns dual mode to its first stage. Any other value written there is ignored.
- R6: Writing exactly 0x1209 to address 0x14 starts a reset pulse, whatever the external reset enable bit holds. Any other value written there is ignored.
- R7: While the enable bit is 0, the count and the partial unit hold their values. A keyed mode write that changes the enable bit from 0 to 1 reloads the full length.
- R8: When both interrupt mode and dual mode are 0, an expiry starts a reset pulse if the external reset enable bit is 1, and does nothing visible if it is 0. In both cases the count reloads and keeps running.
- R9: In interrupt mode, with dual mode 0, an expiry raises `wdt_irq` and does not start a reset pulse. `wdt_irq` stays high until a valid restart write.
- R10: In dual mode, the first expiry raises `wdt_irq`. A second expiry with no restart in between starts a reset pulse, if the external reset enable bit is 1.
- R11: If a valid restart write falls in the same cycle as the strobe that would cause an expiry, the restart wins: there is no expiry, and a full length is reloaded.
- R12: `wdt_rst` stays high for exactly `RST_PULSE` clock cycles, starting the cycle after the event that causes the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe per slow reference period |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data, including the key |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wdt_irq | output | 1 | Watchdog interrupt (level) |
| wdt_rst | output | 1 | Reset request pulse |

## Verification
Two events can land in the same clock edge: a restart write, and the reference strobe that completes the last timeout unit. The bench runs the count to one strobe short of expiry. It then drives the restart code and `ref_tick` together for a single cycle. The design passes only if neither output rises at that point and a full, fresh length has to elapse before the next expiry. The bench also sweeps lengths 1 to 4 across every expiry mode and predicts each expiry edge as length times `PRESCALE` strobes.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int PRESCALE  = 512,
  parameter int LEN_W     = 11,
  parameter int RST_LEN   = 62,
  parameter int RST_PULSE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_irq,
  output logic        wdt_rst
);
  localparam int PS_W = $clog2(PRESCALE);
  localparam int PW_W = $clog2(RST_PULSE + 1);
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic m_en, m_ext, m_irq, m_dual;
  logic [LEN_W-1:0] len_q, cnt;
  logic [PS_W-1:0]  ps;
  logic             stage;
  logic [PW_W-1:0]  pcnt;

  wire wr_mode = bus_wr && bus_addr == 5'h00 && bus_wdata[31:24] == 8'h22;
  wire wr_len  = bus_wr && bus_addr == 5'h04 && bus_wdata[4:0] == 5'h08;
  wire wr_kick = bus_wr && bus_addr == 5'h08 && bus_wdata == 32'h1971;
  wire wr_swr  = bus_wr && bus_addr == 5'h14 && bus_wdata == 32'h1209;

  wire unit     = m_en && ref_tick && ps == PS_LAST;
  wire expire   = unit && cnt <= LEN_W'(1) && !wr_kick;
  wire fire_irq = expire && (m_dual ? !stage : m_irq);
  wire fire_rst = expire && (m_dual ? stage : !m_irq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_en, m_ext, m_irq, m_dual} <= '0;
      len_q <= LEN_W'(RST_LEN);
    end else begin
      if (wr_mode) begin
        m_en   <= bus_wdata[0];
        m_ext  <= bus_wdata[2];
        m_irq  <= bus_wdata[3];
        m_dual <= bus_wdata[6];
      end
      if (wr_len) len_q <= bus_wdata[5 +: LEN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= LEN_W'(RST_LEN);
      ps      <= '0;
      stage   <= 1'b0;
      wdt_irq <= 1'b0;
    end else if (wr_kick) begin
      cnt     <= len_q;
      ps      <= '0;
      stage   <= 1'b0;
      wdt_irq <= 1'b0;
    end else if (wr_mode && bus_wdata[0] && !m_en) begin
      cnt   <= len_q;
      ps    <= '0;
      stage <= 1'b0;
    end else if (m_en && ref_tick) begin
      ps <= (ps == PS_LAST) ? '0 : ps + 1'b1;
      if (unit) cnt <= (cnt <= LEN_W'(1)) ? len_q : cnt - 1'b1;
      if (fire_irq) begin
        wdt_irq <= 1'b1;
        if (m_dual) stage <= 1'b1;
      end
      if (fire_rst) stage <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pcnt <= '0;
    else if (wr_swr || (fire_rst && m_ext)) pcnt <= PW_W'(RST_PULSE);
    else if (pcnt != '0)                 pcnt <= pcnt - 1'b1;
  end

  assign wdt_rst = pcnt != '0;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      5'h00: begin
        bus_rdata[0] = m_en;
        bus_rdata[2] = m_ext;
        bus_rdata[3] = m_irq;
        bus_rdata[6] = m_dual;
      end
      5'h04: bus_rdata[5 +: LEN_W] = len_q;
      default: ;
    endcase
  end

  p_bad_mode_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'h00 && bus_wdata[31:24] != 8'h22)
      |=> $stable({m_en, m_ext, m_irq, m_dual}));

  p_kick_clears_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'h08 && bus_wdata == 32'h1971) |=> !wdt_irq);

  p_swr_pulses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'h14 && bus_wdata == 32'h1209) |=> wdt_rst);

  p_hold_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_en && !wr_kick && !wr_mode) |=> $stable(cnt) && $stable(ps));

  p_irq_needs_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_irq) |-> $past(m_irq || m_dual));
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb_top;
  localparam int P = 4, LW = 6, RL = 5, PW = 5;

  logic clk = 0, rst_n = 0, ref_tick = 0, bus_wr = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic wdt_irq, wdt_rst;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  keyed_watchdog #(.PRESCALE(P), .LEN_W(LW), .RST_LEN(RL), .RST_PULSE(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_irq(wdt_irq), .wdt_rst(wdt_rst));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk); ref_tick = 1;
      repeat (n) @(negedge clk);
      ref_tick = 0;
    end
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse_width(string req);
    int w = 0;
    while (wdt_rst && w < 50) begin w++; @(negedge clk); end
    chk(req, w, PW);
  endtask

  task automatic setup(int len, logic [31:0] mbits);
    wr(5'h00, 32'h2200_0000);
    wr(5'h08, 32'h1971);
    wr(5'h04, (len << 5) | 8);
    wr(5'h00, 32'h2200_0001 | mbits);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run hung actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(5'h00, d); chk("R1 mode", d, 0);
    rd(5'h04, d); chk("R1 len", d, RL << 5);
    chk("R1 irq", wdt_irq, 0); chk("R1 rst", wdt_rst, 0);

    wr(5'h00, 32'h2200_004D); rd(5'h00, d); chk("R2 mode readback", d, 32'h4D);
    wr(5'h00, 32'h2100_0000); rd(5'h00, d); chk("R2 bad key ignored", d, 32'h4D);
    wr(5'h00, 32'h22FF_FFB2); rd(5'h00, d); chk("R2 only mode bits", d, 32'h0);
    wr(5'h04, (7 << 5) | 8); rd(5'h04, d); chk("R3 len readback", d, 7 << 5);
    wr(5'h04, (3 << 5) | 9); rd(5'h04, d); chk("R3 bad key ignored", d, 7 << 5);

    // R4 R8 R9 R10 R12: sweep lengths 1..4 over every expiry mode
    for (int m = 0; m < 4; m++) begin
      for (int len = 1; len <= 4; len++) begin
        logic [31:0] mb;
        mb = (m == 0) ? 32'h4 : (m == 1) ? 32'h0 : (m == 2) ? 32'hC : 32'h44;
        setup(len, mb);
        ticks(len * P - 1);
        chk("R4 early irq", wdt_irq, 0); chk("R4 early rst", wdt_rst, 0);
        ticks(1);
        chk("R8/R9/R10 irq at expiry", wdt_irq, (m >= 2) ? 1 : 0);
        chk("R8 rst at expiry", wdt_rst, (m == 0) ? 1 : 0);
        if (m == 0) pulse_width("R12 expiry pulse");
        if (m == 1) begin
          ticks(len * P);
          chk("R8 reload no ext", wdt_rst, 0);
        end
        if (m == 2) begin
          ticks(len * P);
          chk("R9 irq held", wdt_irq, 1); chk("R9 no rst", wdt_rst, 0);
        end
        if (m == 3) begin
          ticks(len * P - 1);
          chk("R10 no early rst", wdt_rst, 0);
          ticks(1);
          chk("R10 second expiry rst", wdt_rst, 1);
          pulse_width("R12 dual pulse");
        end
      end
    end
    wr(5'h08, 32'h1971);
    chk("R5 restart clears irq", wdt_irq, 0);

    // R5: wrong restart value is ignored, the expiry comes on schedule
    setup(3, 32'h8);
    ticks(3 * P - 2);
    wr(5'h08, 32'h1970);
    ticks(1); chk("R5 bad kick not early", wdt_irq, 0);
    ticks(1); chk("R5 bad kick ignored", wdt_irq, 1);
    wr(5'h08, 32'h1971);
    ticks(3 * P - 1); chk("R5 reload", wdt_irq, 0);
    ticks(1); chk("R5 reload expiry", wdt_irq, 1);

    // R6
    wr(5'h00, 32'h2200_0000);
    wr(5'h14, 32'h1208); chk("R6 bad value ignored", wdt_rst, 0);
    wr(5'h14, 32'h1209); chk("R6 swrst without ext", wdt_rst, 1);
    pulse_width("R12 swrst pulse");

    // R7: disabling holds the count, enabling reloads the full length
    setup(4, 32'h8);
    wr(5'h08, 32'h1971);
    ticks(6);
    wr(5'h00, 32'h2200_0008);
    ticks(50); chk("R7 held while off", wdt_irq, 0);
    wr(5'h00, 32'h2200_0009);
    ticks(4 * P - 1); chk("R7 full reload", wdt_irq, 0);
    ticks(1); chk("R7 expiry after enable", wdt_irq, 1);

    // R3: a length write does not reload the running count
    setup(4, 32'h8);
    ticks(P);
    wr(5'h04, (2 << 5) | 8);
    ticks(3 * P - 1); chk("R3 no reload on len write", wdt_irq, 0);
    ticks(1); chk("R3 old count finishes", wdt_irq, 1);

    // R11: restart and the expiring strobe land in the same cycle
    setup(2, 32'h8);
    ticks(2 * P - 1);
    @(negedge clk); ref_tick = 1; bus_wr = 1; bus_addr = 5'h08; bus_wdata = 32'h1971;
    @(negedge clk); ref_tick = 0; bus_wr = 0;
    chk("R11 restart wins irq", wdt_irq, 0);
    ticks(2 * P - 1); chk("R11 fresh length", wdt_irq, 0);
    ticks(1); chk("R11 next expiry", wdt_irq, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule